// File: doc/BRIEF.md
# Device-Address Decoder with Per-Port Slave Match and Access Protection

This block sits behind three serial-bus target ports of a dual-bank memory: two bank ports, A and B, and one control port that reaches both banks and a small configuration area. After a start condition, the bit engine of the selected port hands over the first byte it received, the device-address byte. That byte holds a seven-bit address and a read/write flag in bit 0, where 1 means read. The decoder decides three things: whether the port drives an acknowledge, which region the transfer targets, and whether the following read or write may go ahead. The result comes out as a registered, one-cycle result strobe.

Each port has its own configuration fields, which come from a configuration store outside the block. They are a slave-address field, a slave-match enable and a two-bit protect code. The decoder copies all three ports' fields when a start condition occurs. Later changes to the store therefore have no effect on a transfer that has already begun. On the control port a second, fixed address reaches the configuration area. It is always accepted, whatever the protect code says. A busy flag from the write controller silences every acknowledge while an internal write is in progress.

Top module: `dev_addr_decoder`

## Requirements
- R1: A memory access is recognised only when address-byte bits 7:4 equal 1010b. Any other code, apart from the configuration address in R4, gives no acknowledge.
- R2: Ports A (id 0) and B (id 1) match byte bits 3:1 against slave bits 2:0. The control port (id 2) matches byte bits 3:2 against slave bits 2:1, and byte bit 1 is its bank select. Port A reports bank 0 and port B reports bank 1.
- R3: When a port's enable field is 0, the slave bits in the byte are ignored for that port.
- R4: On the control port, byte bits 7:1 = 1011100b acknowledge with target CFG (2) and pass the read/write flag through, regardless of protect code. The same byte on port A or B is not acknowledged.
- R5: Protect code 00 gives no acknowledge, target NONE (0), and no read or write allowance.
- R6: Protect code 01 acknowledges with target MEM (1) but allows neither read nor write.
- R7: Protect code 10 allows reads only. Code 11 allows a read when bit 0 is 1 and a write when bit 0 is 0. A read and a write allowance are never given together.
- R8: While busy_i is high, no address is acknowledged.
- R9: After reset, and until the first start, every port uses slave bits 000, enable 1 and protect 11. All outputs are 0 in reset.
- R10: Configuration fields are sampled at start_i. Changes made after the start do not affect decoding until the next start.
- R11: Each addr_valid_i pulse produces exactly one res_valid_o pulse in the next cycle, and outputs are 0 otherwise. Port id 3 is never acknowledged.

Each configuration input is 6 bits: {protect[1:0], enable, slave[2:0]}, with the protect code in bits 5:4, enable in bit 3 and the slave bits in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start condition seen; samples the configuration fields |
| cfg_pa_i | input | 6 | Port A fields {protect, enable, slave} |
| cfg_pb_i | input | 6 | Port B fields |
| cfg_ctl_i | input | 6 | Control port fields |
| busy_i | input | 1 | Internal write in progress |
| addr_valid_i | input | 1 | Address byte present this cycle |
| port_sel_i | input | 2 | Port id: 0 A, 1 B, 2 control, 3 unused |
| addr_byte_i | input | 8 | Received device-address byte |
| res_valid_o | output | 1 | Decode result strobe |
| ack_o | output | 1 | Drive acknowledge |
| target_o | output | 2 | 0 none, 1 memory bank, 2 configuration area |
| bank_sel_o | output | 1 | Bank targeted (valid for target memory) |
| rd_allow_o | output | 1 | Read may proceed |
| wr_allow_o | output | 1 | Write may proceed |

## Verification
A corrupted configuration snapshot does not show up until the next address byte. It then appears on the very next result strobe, as a wrong acknowledge or a missing allowance. The bench therefore changes the fields between starts and probes the port straight after. A fault in the protect or busy gating shows in the same result cycle. The bench covers every protect code, the enable bypass and the fixed configuration address, with both read and write flags.

// File: rtl/dad_pkg.sv
package dad_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_MEM  = 2'd1,
    TGT_CFG  = 2'd2
  } target_e;

  typedef enum logic [1:0] {
    PROT_BLOCK   = 2'b00,
    PROT_ACKONLY = 2'b01,
    PROT_RDONLY  = 2'b10,
    PROT_FULL    = 2'b11
  } prot_e;

  typedef struct packed {
    prot_e      prot;
    logic       en;
    logic [2:0] slv;
  } port_cfg_t;

  localparam int CFG_W = $bits(port_cfg_t);
  localparam port_cfg_t CFG_DEFAULT = '{prot: PROT_FULL, en: 1'b1, slv: 3'b000};
endpackage

// File: rtl/dad_cfg_snapshot.sv
module dad_cfg_snapshot
  import dad_pkg::*;
#(
  parameter int NPORTS = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [NPORTS*CFG_W-1:0]   cfg_flat_i,
  output port_cfg_t [NPORTS-1:0]    snap_o
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        snap_o[p] <= CFG_DEFAULT;
      end else if (start_i) begin
        snap_o[p] <= port_cfg_t'(cfg_flat_i[p*CFG_W +: CFG_W]);
      end
    end
  end
endmodule

// File: rtl/dad_addr_match.sv
module dad_addr_match
  import dad_pkg::*;
#(
  parameter bit       IS_CTL     = 1'b0,
  parameter bit       FIXED_BANK = 1'b0,
  parameter bit [3:0] DEV_CODE   = 4'b1010
) (
  input  logic [7:1] addr_i,
  input  port_cfg_t  cfg_i,
  output logic       hit_o,
  output logic       bank_o
);
  localparam logic [2:0] CMP_MASK = IS_CTL ? 3'b110 : 3'b111;

  logic code_ok;
  logic slave_ok;

  assign code_ok  = (addr_i[7:4] == DEV_CODE);
  assign slave_ok = !cfg_i.en || (((addr_i[3:1] ^ cfg_i.slv) & CMP_MASK) == 3'b000);
  assign hit_o    = code_ok && slave_ok;

  if (IS_CTL) begin : g_ctl_bank
    assign bank_o = addr_i[1];
  end else begin : g_fixed_bank
    assign bank_o = FIXED_BANK;
  end
endmodule

// File: rtl/dad_protect_resolve.sv
module dad_protect_resolve
  import dad_pkg::*;
(
  input  logic    port_ok_i,
  input  logic    mem_hit_i,
  input  logic    cfg_hit_i,
  input  logic    busy_i,
  input  logic    rd_req_i,
  input  logic    bank_i,
  input  prot_e   prot_i,
  output logic    ack_o,
  output target_e tgt_o,
  output logic    bank_o,
  output logic    rd_ok_o,
  output logic    wr_ok_o
);
  always_comb begin
    ack_o   = 1'b0;
    tgt_o   = TGT_NONE;
    bank_o  = 1'b0;
    rd_ok_o = 1'b0;
    wr_ok_o = 1'b0;
    if (!busy_i && port_ok_i) begin
      if (cfg_hit_i) begin
        ack_o   = 1'b1;
        tgt_o   = TGT_CFG;
        rd_ok_o = rd_req_i;
        wr_ok_o = !rd_req_i;
      end else if (mem_hit_i) begin
        case (prot_i)
          PROT_ACKONLY: begin
            ack_o  = 1'b1;
            tgt_o  = TGT_MEM;
            bank_o = bank_i;
          end
          PROT_RDONLY: begin
            ack_o   = 1'b1;
            tgt_o   = TGT_MEM;
            bank_o  = bank_i;
            rd_ok_o = rd_req_i;
          end
          PROT_FULL: begin
            ack_o   = 1'b1;
            tgt_o   = TGT_MEM;
            bank_o  = bank_i;
            rd_ok_o = rd_req_i;
            wr_ok_o = !rd_req_i;
          end
          default: ack_o = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dev_addr_decoder.sv
module dev_addr_decoder
  import dad_pkg::*;
#(
  parameter int       NPORTS      = 3,
  parameter int       CTL_PORT    = 2,
  parameter int       PID_W       = $clog2(NPORTS + 1),
  parameter bit [3:0] DEV_CODE    = 4'b1010,
  parameter bit [6:0] CFG_DEVADDR = 7'b1011100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [5:0]       cfg_pa_i,
  input  logic [5:0]       cfg_pb_i,
  input  logic [5:0]       cfg_ctl_i,
  input  logic             busy_i,
  input  logic             addr_valid_i,
  input  logic [PID_W-1:0] port_sel_i,
  input  logic [7:0]       addr_byte_i,
  output logic             res_valid_o,
  output logic             ack_o,
  output logic [1:0]       target_o,
  output logic             bank_sel_o,
  output logic             rd_allow_o,
  output logic             wr_allow_o
);
  localparam logic [PID_W-1:0] CTL_ID = PID_W'(CTL_PORT);

  logic [NPORTS*CFG_W-1:0] cfg_flat;
  port_cfg_t [NPORTS-1:0]  snap;
  logic [NPORTS-1:0]       hit_v;
  logic [NPORTS-1:0]       bank_v;

  assign cfg_flat = {cfg_ctl_i, cfg_pb_i, cfg_pa_i};

  dad_cfg_snapshot #(.NPORTS(NPORTS)) u_snap (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cfg_flat_i (cfg_flat),
    .snap_o     (snap)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_match
    dad_addr_match #(
      .IS_CTL     (p == CTL_PORT),
      .FIXED_BANK ((p % 2) == 1),
      .DEV_CODE   (DEV_CODE)
    ) u_match (
      .addr_i (addr_byte_i[7:1]),
      .cfg_i  (snap[p]),
      .hit_o  (hit_v[p]),
      .bank_o (bank_v[p])
    );
  end

  logic      port_ok;
  logic      sel_hit;
  logic      sel_bank;
  prot_e     sel_prot;
  logic      cfg_hit;

  always_comb begin
    port_ok  = (32'(port_sel_i) < NPORTS);
    sel_hit  = 1'b0;
    sel_bank = 1'b0;
    sel_prot = PROT_BLOCK;
    if (port_ok) begin
      sel_hit  = hit_v[port_sel_i];
      sel_bank = bank_v[port_sel_i];
      sel_prot = snap[port_sel_i].prot;
    end
  end

  assign cfg_hit = (port_sel_i == CTL_ID) && (addr_byte_i[7:1] == CFG_DEVADDR);

  logic    n_ack, n_bank, n_rd, n_wr;
  target_e n_tgt;

  dad_protect_resolve u_resolve (
    .port_ok_i (port_ok),
    .mem_hit_i (sel_hit),
    .cfg_hit_i (cfg_hit),
    .busy_i    (busy_i),
    .rd_req_i  (addr_byte_i[0]),
    .bank_i    (sel_bank),
    .prot_i    (sel_prot),
    .ack_o     (n_ack),
    .tgt_o     (n_tgt),
    .bank_o    (n_bank),
    .rd_ok_o   (n_rd),
    .wr_ok_o   (n_wr)
  );

  always_ff @(posedge clk) begin
    if (rst || !addr_valid_i) begin
      res_valid_o <= 1'b0;
      ack_o       <= 1'b0;
      target_o    <= TGT_NONE;
      bank_sel_o  <= 1'b0;
      rd_allow_o  <= 1'b0;
      wr_allow_o  <= 1'b0;
    end else begin
      res_valid_o <= 1'b1;
      ack_o       <= n_ack;
      target_o    <= n_tgt;
      bank_sel_o  <= n_bank;
      rd_allow_o  <= n_rd;
      wr_allow_o  <= n_wr;
    end
  end
endmodule

// File: rtl/dad_checker.sv
module dad_checker #(
  parameter int PID_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             busy_i,
  input logic             addr_valid_i,
  input logic [PID_W-1:0] port_sel_i,
  input logic [7:0]       addr_byte_i,
  input logic             res_valid_o,
  input logic             ack_o,
  input logic [1:0]       target_o,
  input logic             bank_sel_o,
  input logic             rd_allow_o,
  input logic             wr_allow_o
);
  assert_devcode_R1: assert property (@(posedge clk) disable iff (rst)
    addr_valid_i && addr_byte_i[7:4] != 4'b1010 && port_sel_i != 2'd2 |=> !ack_o);

  assert_porta_bank_R2: assert property (@(posedge clk) disable iff (rst)
    addr_valid_i && port_sel_i == 2'd0 |=> !bank_sel_o);

  assert_cfg_always_R4: assert property (@(posedge clk) disable iff (rst)
    addr_valid_i && !busy_i && port_sel_i == 2'd2 && addr_byte_i[7:1] == 7'b1011100
    |=> ack_o && target_o == 2'd2);

  assert_nack_idle_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid_o && !ack_o |-> !rd_allow_o && !wr_allow_o && target_o == 2'd0);

  assert_read_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    addr_valid_i && addr_byte_i[0] |=> !wr_allow_o);

  assert_write_no_read_R7: assert property (@(posedge clk) disable iff (rst)
    addr_valid_i && !addr_byte_i[0] |=> !rd_allow_o);

  assert_busy_nack_R8: assert property (@(posedge clk) disable iff (rst)
    addr_valid_i && busy_i |=> res_valid_o && !ack_o);

  assert_one_result_R11: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> $past(addr_valid_i));

  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !res_valid_o |-> !ack_o && !rd_allow_o && !wr_allow_o);

  assert_reserved_port_R11: assert property (@(posedge clk) disable iff (rst)
    addr_valid_i && port_sel_i == 2'd3 |=> !ack_o);
endmodule

bind dev_addr_decoder dad_checker #(.PID_W(PID_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy_i       (busy_i),
  .addr_valid_i (addr_valid_i),
  .port_sel_i   (port_sel_i),
  .addr_byte_i  (addr_byte_i),
  .res_valid_o  (res_valid_o),
  .ack_o        (ack_o),
  .target_o     (target_o),
  .bank_sel_o   (bank_sel_o),
  .rd_allow_o   (rd_allow_o),
  .wr_allow_o   (wr_allow_o)
);

// File: tb/dev_addr_decoder_bench.sv
module dev_addr_decoder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [5:0] cfg_pa_i = 6'h38, cfg_pb_i = 6'h38, cfg_ctl_i = 6'h38;
  logic busy_i = 1'b0;
  logic addr_valid_i = 1'b0;
  logic [1:0] port_sel_i = 2'd0;
  logic [7:0] addr_byte_i = 8'h00;
  logic res_valid_o, ack_o, bank_sel_o, rd_allow_o, wr_allow_o;
  logic [1:0] target_o;

  always #5 clk = ~clk;

  dev_addr_decoder u_dev_addr_decoder (.*);

  typedef struct {
    logic       ack;
    logic [1:0] tgt;
    logic       bank;
    logic       rd;
    logic       wr;
    string      tag;
  } exp_t;

  exp_t q[$];
  int errs = 0;
  int checks = 0;
  logic [5:0] m_snap [3] = '{6'h38, 6'h38, 6'h38};

  function automatic exp_t model(int port, logic [7:0] a, logic busy, string tag);
    exp_t e;
    logic [5:0] f;
    logic slv_ok;
    e.ack = 0; e.tgt = 0; e.bank = 0; e.rd = 0; e.wr = 0; e.tag = tag;
    if (busy || port == 3) return e;
    if (port == 2 && a[7:1] == 7'b1011100) begin
      e.ack = 1; e.tgt = 2; e.rd = a[0]; e.wr = !a[0];
      return e;
    end
    f = m_snap[port];
    slv_ok = !f[3] || (port == 2 ? a[3:2] == f[2:1] : a[3:1] == f[2:0]);
    if (a[7:4] != 4'b1010 || !slv_ok || f[5:4] == 2'b00) return e;
    e.ack = 1; e.tgt = 1;
    e.bank = (port == 2) ? a[1] : (port == 1);
    if (f[5:4] != 2'b01) e.rd = a[0];
    if (f[5:4] == 2'b11) e.wr = !a[0];
    return e;
  endfunction

  task automatic send(int port, logic [7:0] a, string tag);
    @(negedge clk);
    port_sel_i   = 2'(port);
    addr_byte_i  = a;
    addr_valid_i = 1'b1;
    q.push_back(model(port, a, busy_i, tag));
    @(negedge clk);
    addr_valid_i = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk);
    start_i = 1'b1;
    m_snap[0] = cfg_pa_i; m_snap[1] = cfg_pb_i; m_snap[2] = cfg_ctl_i;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && res_valid_o) begin
      checks++;
      if (q.size() == 0) begin
        errs++;
        $display("FAIL R11: result strobe with nothing expected, actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        if ({ack_o, target_o, bank_sel_o, rd_allow_o, wr_allow_o} !=
            {e.ack, e.tgt, e.bank, e.rd, e.wr}) begin
          errs++;
          $display("FAIL %s: ack/tgt/bank/rd/wr actual=%b/%0d/%b/%b/%b expected=%b/%0d/%b/%b/%b",
                   e.tag, ack_o, target_o, bank_sel_o, rd_allow_o, wr_allow_o,
                   e.ack, e.tgt, e.bank, e.rd, e.wr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({res_valid_o, ack_o, target_o, rd_allow_o, wr_allow_o} != 6'b0) begin
      errs++;
      $display("FAIL R9: outputs in reset actual=%b expected=0",
               {res_valid_o, ack_o, target_o, rd_allow_o, wr_allow_o});
    end
    @(negedge clk); rst = 1'b0;

    // Defaults before any start
    send(0, 8'hA0, "R9");
    send(1, 8'hA1, "R9_R2");
    send(2, 8'hA2, "R2");
    send(2, 8'hAC, "R2");
    send(0, 8'hB0, "R1");
    send(0, 8'hB8, "R4");

    // Idle: no strobe without a request
    @(negedge clk);
    checks++;
    if (res_valid_o || ack_o) begin
      errs++;
      $display("FAIL R11: idle strobe actual=%b expected=0", res_valid_o);
    end

    // New configuration
    cfg_pa_i  = 6'h3D; // protect 11, enable 1, slave 101
    cfg_pb_i  = 6'h23; // protect 10, enable 0, slave 011
    cfg_ctl_i = 6'h1E; // protect 01, enable 1, slave 110
    do_start();
    send(0, 8'hAA, "R2");
    send(0, 8'hA0, "R2");
    send(1, 8'hAE, "R3_R7");
    send(1, 8'hA7, "R3_R7");
    send(2, 8'hAC, "R6");
    send(2, 8'hAD, "R6");
    send(2, 8'hA0, "R2");
    send(2, 8'hB8, "R4");
    send(2, 8'hB9, "R4");

    // Mid-transfer change is not seen until the next start
    cfg_pa_i = 6'h00;
    send(0, 8'hAA, "R10");
    do_start();
    send(0, 8'hAA, "R5");
    send(0, 8'hAB, "R5");

    // Busy suppresses everything
    busy_i = 1'b1;
    send(2, 8'hB8, "R8");
    send(1, 8'hA7, "R8");
    busy_i = 1'b0;
    send(1, 8'hA7, "R8");

    send(3, 8'hA0, "R11");

    repeat (4) @(negedge clk);
    while (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      errs++; checks++;
      $display("FAIL %s: result missing, actual=none expected=strobe", e.tag);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule